// File: doc/BRIEF.md
# I2C SCL Clock Period Generator

This block drives the serial clock line of an I2C master. Its time base is the prescaled clock that arrives on `clk`, and every length below counts cycles of that clock. A 3-bit code selects the speed. For code value c, the low phase lasts 2^(c+4) cycles. The high phase lasts 8 cycles more than the low phase, so one full SCL period is 2^(c+5) + 8 cycles.

The transfer engine starts and stops the clock with `en`. It uses `go` to hold SCL low until it is ready for the next bit. Each SCL transition comes with a one-cycle pulse on `fall_tick` or `rise_tick`, and the engine uses these pulses to move and sample its data. The block reads the code only when a phase begins. A change to the code therefore never cuts short or stretches the phase that is running. Code 7 is reserved and keeps the line idle.

Top module: `scl_period_gen`

## Requirements
- R1: While `rst_n` is low, and on the clock edge after `en` is sampled low, `scl` is 1 and neither tick pulses. A disable that arrives during a low phase releases `scl` with no `rise_tick`.
- R2: From idle, with `en` high and `sel` in 0..6, `scl` falls at the next clock edge and `fall_tick` is 1 for that one cycle.
- R3: A low phase started with code value c lasts 2^(c+4) cycles when `go` is 1. For codes 0..6 that is 16 to 1024 cycles.
- R4: A high phase started with code value c lasts 2^(c+4)+8 cycles. For codes 0..6 that is 24 to 1032 cycles.
- R5: `fall_tick` is 1 only in the cycle after `scl` goes from 1 to 0. `rise_tick` is 1 only in the cycle after `scl` goes from 0 to 1. The two are never 1 together. Every edge from the counter carries its tick.
- R6: The code is sampled at the start of each phase. A change to `sel` during a phase takes effect from the next phase only.
- R7: When its count is done, a low phase ends only at a clock edge where `go` is 1. It stays low for as long as `go` is 0.
- R8: Code 7 is reserved. With code 7, `scl` does not fall. A low phase that ends with code 7 releases `scl` with `rise_tick`, and the block then stays idle until a valid code is present.
- R9: After a disable, the next enable begins with a full low phase of the length the code gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaled clock; all phase lengths count its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run request from the transfer engine |
| sel | input | 3 | Speed code: 0..6 valid, 7 reserved |
| go | input | 1 | Engine ready; when 0 the low phase is held |
| scl | output | 1 | Serial clock level (1 = released) |
| fall_tick | output | 1 | One-cycle pulse with each falling edge of `scl` |
| rise_tick | output | 1 | One-cycle pulse with each rising edge of `scl` |

## Verification
Every output comes from a register. A start or a disable therefore shows at the first clock edge after the input is sampled, and a raised `go` ends a held low phase at the edge that follows. If a tick is seen at cycle k, the next edge falls at k + 2^(c+4), or 8 cycles later than that for a high phase. The bench drives its inputs and samples the outputs on the falling clock edge. It counts falling edges from one tick to the next and compares the count with phase lengths computed from the code that was valid when each phase began.

// File: rtl/scl_period_gen.sv
module scl_period_gen #(
  parameter int CODE_W     = 3,
  parameter int BASE_SHIFT = 4,
  parameter int HIGH_EXTRA = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] sel,
  input  logic              go,
  output logic              scl,
  output logic              fall_tick,
  output logic              rise_tick
);
  localparam int RESV  = (1 << CODE_W) - 1;
  localparam int MAXHI = (1 << (BASE_SHIFT + RESV - 1)) + HIGH_EXTRA;
  localparam int CNT_W = $clog2(MAXHI);

  logic             active;
  logic [CNT_W-1:0] cnt, low_len, high_len;
  logic             resv;

  always_comb begin
    low_len  = CNT_W'(32'd1 << (BASE_SHIFT + 32'(sel)));
    high_len = low_len + CNT_W'(HIGH_EXTRA);
  end

  assign resv = (sel == CODE_W'(RESV));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl <= 1'b1; active <= 1'b0; cnt <= '0;
      fall_tick <= 1'b0; rise_tick <= 1'b0;
    end else begin
      fall_tick <= 1'b0;
      rise_tick <= 1'b0;
      if (!en) begin
        scl <= 1'b1; active <= 1'b0; cnt <= '0;
      end else if (!active) begin
        if (!resv) begin
          active <= 1'b1; scl <= 1'b0; fall_tick <= 1'b1;
          cnt <= low_len - 1'b1;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else if (!scl) begin
        if (go) begin
          scl <= 1'b1; rise_tick <= 1'b1;
          if (resv) active <= 1'b0;
          else      cnt <= high_len - 1'b1;
        end
      end else begin
        if (resv) active <= 1'b0;
        else begin
          scl <= 1'b0; fall_tick <= 1'b1;
          cnt <= low_len - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scl_period_gen_chk.sv
module scl_period_gen_chk #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [CODE_W-1:0] sel,
  input logic              go,
  input logic              scl,
  input logic              fall_tick,
  input logic              rise_tick
);
  AST_TICKS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_tick && rise_tick)); // R5
  AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |-> (!scl && $past(scl))); // R5
  AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |-> (scl && !$past(scl))); // R5
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (scl && !fall_tick && !rise_tick)); // R1
  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl) && $past(en)) |-> $past(go)); // R7
  AST_RESV_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl) && $past(sel) == {CODE_W{1'b1}}) |-> !fall_tick); // R8
endmodule

bind scl_period_gen scl_period_gen_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sel(sel), .go(go),
  .scl(scl), .fall_tick(fall_tick), .rise_tick(rise_tick)
);

// File: tb/scl_period_gen_tb.sv
module scl_period_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, go = 1'b1;
  logic [2:0] sel = 3'd0;
  logic scl, fall_tick, rise_tick;
  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_period_gen u_dut (.clk(clk), .rst_n(rst_n), .en(en), .sel(sel), .go(go),
    .scl(scl), .fall_tick(fall_tick), .rise_tick(rise_tick));

  function automatic int low_exp(int c);  return 1 << (c + 4); endfunction
  function automatic int high_exp(int c); return low_exp(c) + 8; endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts falling clock edges until the wanted tick; checks level and exclusivity
  task automatic wait_tick(input bit want_rise, output int n);
    bit hit;
    bit bad_lvl;
    bit both;
    n = 0; hit = 0; bad_lvl = 0; both = 0;
    while (!hit && n < 4000) begin
      @(negedge clk); n++;
      if (fall_tick && rise_tick) both = 1;
      hit = want_rise ? rise_tick : fall_tick;
      if (!hit && (fall_tick || rise_tick || scl != !want_rise)) bad_lvl = 1;
    end
    chk(!both, "R5 tick exclusive", int'(both), 0);
    chk(!bad_lvl, "R5 level steady, no stray tick", int'(bad_lvl), 0);
    chk(hit && scl == want_rise, "R5 tick matches scl", int'(scl), int'(want_rise));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int n, prev, s;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(scl && !fall_tick && !rise_tick, "R1 reset idle", int'(scl), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(scl && !fall_tick && !rise_tick, "R1 disabled idle", int'(scl), 1);

    sel = 3'd0; en = 1'b1;
    @(negedge clk);
    chk(fall_tick && !scl, "R2 start falls next edge", int'(fall_tick), 1);
    wait_tick(1'b1, n); chk(n == low_exp(0), "R3 low len code0", n, low_exp(0));
    wait_tick(1'b0, n); chk(n == high_exp(0), "R4 high len code0", n, high_exp(0));

    prev = 0;
    for (int i = 0; i < 12; i++) begin
      s = int'($urandom % 7);
      sel = 3'(s);
      wait_tick(1'b1, n); chk(n == low_exp(prev), "R3 R6 low len random", n, low_exp(prev));
      wait_tick(1'b0, n); chk(n == high_exp(s), "R4 R6 high len random", n, high_exp(s));
      prev = s;
    end

    go = 1'b0;
    for (int k = 0; k < low_exp(prev) + 5; k++) begin
      @(negedge clk);
      if (scl || rise_tick) chk(1'b0, "R7 held low", int'(scl), 0);
    end
    chk(!scl, "R7 still low past count", int'(scl), 0);
    go = 1'b1;
    @(negedge clk);
    chk(rise_tick && scl, "R7 release on go", int'(rise_tick), 1);
    wait_tick(1'b0, n); chk(n == high_exp(prev), "R4 high after hold", n, high_exp(prev));

    sel = 3'd7;
    wait_tick(1'b1, n); chk(n == low_exp(prev), "R8 low ends with tick", n, low_exp(prev));
    begin
      bit bad;
      bad = 0;
      repeat (1200) begin
        @(negedge clk);
        if (!scl || fall_tick || rise_tick) bad = 1;
      end
      chk(!bad, "R8 reserved stays idle", int'(bad), 0);
    end
    sel = 3'd1;
    @(negedge clk);
    chk(fall_tick && !scl, "R8 R2 restart after valid code", int'(fall_tick), 1);
    wait_tick(1'b1, n); chk(n == low_exp(1), "R3 low len code1", n, low_exp(1));
    wait_tick(1'b0, n);

    repeat (5) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(scl && !rise_tick, "R1 disable releases without tick", int'(rise_tick), 0);
    begin
      bit bad;
      bad = 0;
      repeat (10) begin
        @(negedge clk);
        if (!scl || fall_tick || rise_tick) bad = 1;
      end
      chk(!bad, "R1 idle while disabled", int'(bad), 0);
    end
    sel = 3'd2; en = 1'b1;
    @(negedge clk);
    chk(fall_tick && !scl, "R9 re-enable falls", int'(fall_tick), 1);
    wait_tick(1'b1, n); chk(n == low_exp(2), "R9 full low phase", n, low_exp(2));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule